// File: doc/BRIEF.md
# I2C Bus Master with Clock Stretching and Arbitration

This block is a byte-oriented controller for a two-wire I2C bus whose clock and data lines are open drain. Each line is handled as a pull-low enable going out and a raw level coming back. The raw level passes through a flop synchronizer before use. A host issues one command at a time: create a START (or a repeated START while a transfer is open), write a byte, read a byte, or create a STOP. When the command finishes, the block reports through a one-cycle done pulse, a slave-acknowledge flag, the received byte and a sticky arbitration-loss flag.

A slave may hold the clock line low for as long as it likes. The block never counts a clock high phase until it has actually read the line high. The length of every low and high phase comes from a half-period count on an input port, so it can be changed between transactions.

While it sends a byte, the block compares every bit it releases with the level it reads back. If another master pulls the data line low at that point, the block releases both lines at once, abandons the rest of the byte and raises the loss flag.

Top module: `i2c_arb_master`

## Requirements
- R1: A START pulls SDA low while SCL is high, and a STOP releases SDA while SCL is high. During write and read commands, SDA changes only while the master holds SCL low.
- R2: When a STOP command completes, both pull-low enables are deasserted and both lines read high.
- R3: A write command shifts out `cmd_byte` MSB first and releases SDA in the ninth clock. `ack_ok` is 1 exactly when the slave held SDA low in that clock. The address byte is the 7-bit address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write).
- R4: A read command samples 8 bits, MSB first, at SCL rising edges into `rx_byte`. In the ninth clock the master pulls SDA low when `cmd_nack` is 0 (ACK) and releases it when `cmd_nack` is 1 (NACK).
- R5: A START issued while a transfer is open produces a new START condition with no STOP in between, and the transfer then continues with the new address.
- R6: While a slave holds SCL low, the master waits. Every SCL high phase inside a byte lasts at least `half_div`+1 clock cycles, counted from when SCL reads high, and the master pulls SCL low only after it has read it high.
- R7: Every SCL low phase inside a byte lasts at least `half_div`+1 clock cycles.
- R8: Command codes: 0 = START, 1 = WRITE, 2 = READ, 3 = STOP. A command is taken when `cmd_valid` is high and `busy` is low. `busy` then stays high until completion, and `done` pulses for one cycle as `busy` falls.
- R9: If SDA reads low during a write data bit in which the master released it, the master releases both lines, sends no further clocks, ends the command with `done` and sets `arb_lost`. `arb_lost` stays set until the next command is accepted.
- R10: After reset, both lines are released, and `busy`, `done`, `ack_ok` and `arb_lost` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Length of each SCL low/high phase, minus one, in clock cycles |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 2 | Command code (see R8) |
| cmd_byte | input | 8 | Byte to send for a write command |
| cmd_nack | input | 1 | For a read command: 1 sends NACK, 0 sends ACK |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_ok | output | 1 | Slave acknowledged the last written byte |
| rx_byte | output | 8 | Last byte received |
| arb_lost | output | 1 | Arbitration was lost in the last command |
| scl_i | input | 1 | Level read on the clock line |
| sda_i | input | 1 | Level read on the data line |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |

## Verification
The bench builds the block with a 4-bit divider and a three-stage synchronizer. With these values it can draw half-period counts from 0 to 4 for each transaction, including the single-cycle case. The longer synchronizer delay makes sure the stretch wait and the high-phase count are measured against a late view of the line. A bus model on the bench side decodes START and STOP, acknowledges, and serves read data with random clock stretching. A second driver pulls SDA low in the middle of a byte to force an arbitration loss.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [1:0] {
      CMD_START = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2,
      CMD_STOP  = 2'd3
   } cmd_e;

   typedef enum logic [1:0] {
      BOP_START = 2'd0,
      BOP_STOP  = 2'd1,
      BOP_BIT   = 2'd2
   } bop_e;

   localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cm_bit_eng.sv
module i2cm_bit_eng
   import i2cm_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  bop_e             op,
   input  logic             tx_bit,
   input  logic             arb_en,
   input  logic [DIV_W-1:0] half_div,
   input  logic             scl_s,
   input  logic             sda_s,
   output logic             done,
   output logic             rx_bit,
   output logic             lost,
   output logic             scl_oe,
   output logic             sda_oe
);
   typedef enum logic [3:0] {
      E_IDLE, E_S1, E_S2, E_S3, E_S4, E_P1, E_P2, E_P3, E_B1, E_B2
   } est_e;

   est_e             st;
   logic [DIV_W-1:0] cnt;
   logic             hi_seen;
   logic             tx_q;
   logic             arb_q;
   logic             tick;

   assign tick = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= E_IDLE;
         cnt     <= '0;
         hi_seen <= 1'b0;
         done    <= 1'b0;
         lost    <= 1'b0;
         rx_bit  <= 1'b0;
         scl_oe  <= 1'b0;
         sda_oe  <= 1'b0;
         tx_q    <= 1'b1;
         arb_q   <= 1'b0;
      end else begin
         done <= 1'b0;
         lost <= 1'b0;
         case (st)
            E_IDLE: if (go) begin
               cnt     <= half_div;
               hi_seen <= 1'b0;
               tx_q    <= tx_bit;
               arb_q   <= arb_en;
               case (op)
                  BOP_START: begin sda_oe <= 1'b0; st <= E_S1; end
                  BOP_STOP:  begin scl_oe <= 1'b1; sda_oe <= 1'b1; st <= E_P1; end
                  default:   begin sda_oe <= !tx_bit; st <= E_B1; end
               endcase
            end
            E_S1, E_P1, E_B1: begin
               if (tick) begin
                  scl_oe <= 1'b0;
                  cnt    <= half_div;
                  st     <= (st == E_S1) ? E_S2 : ((st == E_P1) ? E_P2 : E_B2);
               end else cnt <= cnt - 1'b1;
            end
            E_S2, E_P2, E_B2: begin
               if (!hi_seen) begin
                  if (scl_s) begin
                     hi_seen <= 1'b1;
                     cnt     <= half_div;
                     if (st == E_B2) begin
                        rx_bit <= sda_s;
                        if (arb_q && tx_q && !sda_s) begin
                           lost   <= 1'b1;
                           done   <= 1'b1;
                           scl_oe <= 1'b0;
                           sda_oe <= 1'b0;
                           st     <= E_IDLE;
                        end
                     end
                  end
               end else if (tick) begin
                  hi_seen <= 1'b0;
                  cnt     <= half_div;
                  case (st)
                     E_S2:    begin sda_oe <= 1'b1; st <= E_S3; end
                     E_P2:    begin sda_oe <= 1'b0; st <= E_P3; end
                     default: begin scl_oe <= 1'b1; done <= 1'b1; st <= E_IDLE; end
                  endcase
               end else cnt <= cnt - 1'b1;
            end
            E_S3: begin
               if (tick) begin
                  scl_oe <= 1'b1;
                  cnt    <= half_div;
                  st     <= E_S4;
               end else cnt <= cnt - 1'b1;
            end
            E_S4, E_P3: begin
               if (tick) begin
                  done <= 1'b1;
                  st   <= E_IDLE;
               end else cnt <= cnt - 1'b1;
            end
            default: st <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
   import i2cm_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_div,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_code,
   input  logic [7:0]       cmd_byte,
   input  logic             cmd_nack,
   output logic             busy,
   output logic             done,
   output logic             ack_ok,
   output logic [7:0]       rx_byte,
   output logic             arb_lost,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             scl_oe,
   output logic             sda_oe
);
   localparam int IDX_W = $clog2(BYTE_BITS + 1);
   localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(BYTE_BITS - 1);
   localparam logic [IDX_W-1:0] ACK_SLOT  = IDX_W'(BYTE_BITS);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("i2c_arb_master: DIV_W must be at least 1");
      end
   endgenerate

   logic             scl_s, sda_s;
   logic             eng_done, eng_rx, eng_lost;
   logic             go, tx, arb_en;
   bop_e             op;
   cmd_e             cur;
   logic [7:0]       sh;
   logic [IDX_W-1:0] idx;
   logic             nack_q;
   cmd_e             req;

   assign req = cmd_e'(cmd_code);

   i2cm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     ({scl_s, sda_s})
   );

   i2cm_bit_eng #(.DIV_W(DIV_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .op       (op),
      .tx_bit   (tx),
      .arb_en   (arb_en),
      .half_div (half_div),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .done     (eng_done),
      .rx_bit   (eng_rx),
      .lost     (eng_lost),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         ack_ok   <= 1'b0;
         rx_byte  <= '0;
         arb_lost <= 1'b0;
         go       <= 1'b0;
         tx       <= 1'b1;
         arb_en   <= 1'b0;
         op       <= BOP_START;
         cur      <= CMD_START;
         sh       <= '0;
         idx      <= '0;
         nack_q   <= 1'b1;
      end else begin
         go   <= 1'b0;
         done <= 1'b0;
         if (!busy) begin
            if (cmd_valid) begin
               busy     <= 1'b1;
               go       <= 1'b1;
               cur      <= req;
               arb_lost <= 1'b0;
               sh       <= cmd_byte;
               nack_q   <= cmd_nack;
               idx      <= '0;
               case (req)
                  CMD_START: op <= BOP_START;
                  CMD_STOP:  op <= BOP_STOP;
                  CMD_WRITE: begin
                     op     <= BOP_BIT;
                     tx     <= cmd_byte[7];
                     arb_en <= 1'b1;
                     ack_ok <= 1'b0;
                  end
                  default: begin
                     op      <= BOP_BIT;
                     tx      <= 1'b1;
                     arb_en  <= 1'b0;
                     rx_byte <= '0;
                  end
               endcase
            end
         end else if (eng_done) begin
            if (eng_lost) begin
               arb_lost <= 1'b1;
               busy     <= 1'b0;
               done     <= 1'b1;
            end else if (cur == CMD_START || cur == CMD_STOP) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else if (idx == ACK_SLOT) begin
               if (cur == CMD_WRITE) ack_ok <= !eng_rx;
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               if (cur == CMD_READ) rx_byte <= {rx_byte[6:0], eng_rx};
               sh  <= {sh[6:0], 1'b0};
               idx <= idx + 1'b1;
               go  <= 1'b1;
               if (idx == LAST_DATA) begin
                  tx     <= (cur == CMD_WRITE) ? 1'b1 : nack_q;
                  arb_en <= 1'b0;
               end else begin
                  tx     <= (cur == CMD_WRITE) ? sh[6] : 1'b1;
                  arb_en <= (cur == CMD_WRITE);
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2c_arb_master_chk.sv
module i2c_arb_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [1:0] cmd_code,
   input logic       busy,
   input logic       done,
   input logic       arb_lost,
   input logic       scl_i,
   input logic       scl_oe,
   input logic       sda_oe
);
   logic [1:0] cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cmd_q <= 2'd0;
      else if (cmd_valid && !busy) cmd_q <= cmd_code;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8
   AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> (!scl_oe && !sda_oe)); // R9
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cmd_q == 2'd3) |-> (!scl_oe && !sda_oe)); // R2
   AST_SCL_PULL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(scl_i)); // R6
   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cmd_q == 2'd1 || cmd_q == 2'd2) && $changed(sda_oe)) |-> $past(scl_oe)); // R1
endmodule

bind i2c_arb_master i2c_arb_master_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .busy      (busy),
   .done      (done),
   .arb_lost  (arb_lost),
   .scl_i     (scl_i),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe)
);

// File: tb/i2c_arb_master_bench.sv
module i2c_arb_master_bench;
   localparam int DIV_W = 4;
   localparam int SYNC  = 3;
   localparam logic [1:0] C_START = 2'd0, C_WRITE = 2'd1, C_READ = 2'd2, C_STOP = 2'd3;
   localparam logic [6:0] SLV_ADDR = 7'h2A;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] half_div = 4'd2;
   logic             cmd_valid = 1'b0;
   logic [1:0]       cmd_code = 2'd0;
   logic [7:0]       cmd_byte = 8'd0;
   logic             cmd_nack = 1'b0;
   logic             busy, done, ack_ok, arb_lost, scl_oe, sda_oe;
   logic [7:0]       rx_byte;
   logic             scl_w, sda_w;

   bit slv_scl_low = 1'b0, slv_sda_low = 1'b0, rival_low = 1'b0, rival_arm = 1'b0;
   assign scl_w = ~(scl_oe | slv_scl_low);
   assign sda_w = ~(sda_oe | slv_sda_low | rival_low);

   i2c_arb_master #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC)) u_i2c_arb_master (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .busy(busy),
      .done(done), .ack_ok(ack_ok), .rx_byte(rx_byte), .arb_lost(arb_lost),
      .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

   int n_chk = 0, n_err = 0;
   int start_cnt = 0, stop_cnt = 0, scl_rise = 0, viol = 0, cur_div = 2;
   bit in_xfer = 1'b0;
   bit stretch_en = 1'b0;
   int stretch_ns = 40;

   function automatic logic [7:0] rd_pat(input int n);
      return 8'(n * 37 + 5);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bus slave model
   bit s_act = 0, s_first = 0, s_match = 0, s_rw = 0, slv_ack_en = 1, m_ack_last = 0;
   int s_bit = 0, s_phase = 0, rd_idx = 0;
   bit [7:0] s_sh = 0, rd_sh = 0, wr_last = 0;

   always @(negedge sda_w) if (scl_w === 1'b1) begin
      start_cnt++; s_act = 1; s_first = 1; s_bit = 0; s_phase = 0; slv_sda_low = 0;
   end
   always @(posedge sda_w) if (scl_w === 1'b1) begin
      stop_cnt++; s_act = 0; slv_sda_low = 0;
   end
   always @(posedge scl_w) begin
      scl_rise++;
      if (s_act) begin
         if (s_bit < 8) s_sh = {s_sh[6:0], sda_w};
         else if (s_phase == 2) m_ack_last = sda_w;
      end
   end
   always @(negedge scl_w) begin
      if (rival_arm) begin rival_low = 1; rival_arm = 0; end
      if (s_act && s_first) s_first = 0;
      else if (s_act) begin
         if (s_bit == 7) begin
            s_bit = 8;
            if (s_phase == 0) begin
               s_match = (s_sh[7:1] == SLV_ADDR); s_rw = s_sh[0]; slv_sda_low = s_match;
            end else if (s_phase == 1) begin
               wr_last = s_sh; slv_sda_low = slv_ack_en;
            end else slv_sda_low = 0;
         end else if (s_bit == 8) begin
            s_bit = 0;
            if (s_phase == 0) begin
               if (!s_match) begin s_act = 0; slv_sda_low = 0; end
               else if (s_rw) begin
                  s_phase = 2; rd_sh = rd_pat(rd_idx); rd_idx++; slv_sda_low = !rd_sh[7];
               end else begin s_phase = 1; slv_sda_low = 0; end
            end else if (s_phase == 1) slv_sda_low = 0;
            else if (m_ack_last) begin s_act = 0; slv_sda_low = 0; end
            else begin rd_sh = rd_pat(rd_idx); rd_idx++; slv_sda_low = !rd_sh[7]; end
         end else begin
            s_bit++;
            if (s_phase == 2) slv_sda_low = !rd_sh[7 - s_bit];
         end
      end
   end
   always @(negedge scl_w) if (stretch_en && rst_n) begin
      slv_scl_low = 1; #(stretch_ns); slv_scl_low = 0;
   end

   // SCL phase length monitor (R6, R7)
   logic prev_scl = 1'b1; int plen = 0; bit p_ok = 0;
   always @(negedge clk) if (rst_n) begin
      if (scl_w === prev_scl) plen++;
      else begin
         if (p_ok && busy && in_xfer && plen < cur_div + 1) viol++;
         p_ok = busy && in_xfer; plen = 1; prev_scl = scl_w;
      end
   end

   task automatic do_cmd(input logic [1:0] code, input logic [7:0] b, input logic nk);
      int t;
      in_xfer = (code == C_WRITE || code == C_READ);
      @(negedge clk);
      cmd_valid = 1; cmd_code = code; cmd_byte = b; cmd_nack = nk;
      @(negedge clk);
      cmd_valid = 0;
      chk(busy == 1'b1, "R8 busy after accept", busy, 1);
      t = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
      if (!done) chk(0, "R8 command timeout", 0, 1);
      else begin
         chk(busy == 1'b0, "R8 busy low at done", busy, 0);
         @(negedge clk);
         chk(done == 1'b0, "R8 done single pulse", done, 0);
      end
      in_xfer = 0;
   endtask

   task automatic do_start(input string tag);
      int s0, p0;
      s0 = start_cnt; p0 = stop_cnt;
      do_cmd(C_START, 8'h00, 1'b0);
      chk(start_cnt == s0 + 1, {tag, " START seen"}, start_cnt - s0, 1);
      chk(stop_cnt == p0, {tag, " no STOP at START"}, stop_cnt - p0, 0);
   endtask

   task automatic do_stop();
      int p0;
      p0 = stop_cnt;
      do_cmd(C_STOP, 8'h00, 1'b0);
      chk(stop_cnt == p0 + 1, "R1 STOP seen", stop_cnt - p0, 1);
      repeat (2) @(negedge clk);
      chk(scl_oe == 0 && sda_oe == 0, "R2 lines released", {scl_oe, sda_oe}, 0);
      chk(scl_w == 1 && sda_w == 1, "R2 lines high", {scl_w, sda_w}, 3);
   endtask

   task automatic do_read(input bit nk, inout int exp_idx);
      logic [7:0] exp;
      exp = rd_pat(exp_idx); exp_idx++;
      do_cmd(C_READ, 8'h00, nk);
      chk(rx_byte == exp, "R4 read data", rx_byte, exp);
      chk(m_ack_last == nk, "R4 master ack bit", m_ack_last, nk);
   endtask

   int exp_rd = 0;

   initial begin
      int r0;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      chk(scl_oe == 0, "R10 scl_oe reset", scl_oe, 0);
      chk(sda_oe == 0, "R10 sda_oe reset", sda_oe, 0);
      chk(busy == 0 && done == 0, "R10 busy/done reset", {busy, done}, 0);
      chk(ack_ok == 0 && arb_lost == 0, "R10 flags reset", {ack_ok, arb_lost}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // directed: write then repeated start and read (R5), with stretching
      half_div = 4'd3; cur_div = 3; stretch_en = 1; stretch_ns = 90;
      do_start("R1");
      do_cmd(C_WRITE, {SLV_ADDR, 1'b0}, 1'b0);
      chk(ack_ok == 1, "R3 address ack", ack_ok, 1);
      do_cmd(C_WRITE, 8'h3C, 1'b0);
      chk(wr_last == 8'h3C, "R3 data byte MSB first", wr_last, 8'h3C);
      do_start("R5");
      do_cmd(C_WRITE, {SLV_ADDR, 1'b1}, 1'b0);
      chk(ack_ok == 1, "R5 address ack after repeated START", ack_ok, 1);
      do_read(1'b0, exp_rd);
      do_read(1'b1, exp_rd);
      do_stop();
      chk(viol == 0, "R6 R7 phase lengths with stretching", viol, 0);

      // directed: arbitration loss in the second bit of 0x55 (R9)
      stretch_en = 0; half_div = 4'd2; cur_div = 2;
      do_start("R1");
      rival_arm = 1;
      r0 = scl_rise;
      do_cmd(C_WRITE, 8'h55, 1'b0);
      chk(arb_lost == 1, "R9 loss flagged", arb_lost, 1);
      chk(scl_oe == 0 && sda_oe == 0, "R9 lines released", {scl_oe, sda_oe}, 0);
      chk(scl_rise - r0 == 2, "R9 clocks stop at lost bit", scl_rise - r0, 2);
      repeat (100) @(negedge clk);
      chk(scl_rise - r0 == 2, "R9 no clocks after loss", scl_rise - r0, 2);
      chk(arb_lost == 1, "R9 loss flag sticky", arb_lost, 1);
      rival_low = 0;
      repeat (10) @(negedge clk);
      do_start("R1");
      chk(arb_lost == 0, "R9 flag cleared by next command", arb_lost, 0);
      do_stop();

      // constrained random transactions
      for (int it = 0; it < 40; it++) begin
         bit match, rw, rs;
         int nb;
         logic [6:0] addr;
         cur_div = $urandom % 5; half_div = DIV_W'(cur_div);
         stretch_en = ($urandom % 2) == 1; stretch_ns = 20 + ($urandom % 100);
         match = ($urandom % 4) != 0;
         addr = match ? SLV_ADDR : (SLV_ADDR ^ 7'(1 + $urandom % 127));
         rw = $urandom % 2; nb = 1 + $urandom % 3; rs = ($urandom % 3) == 0;
         viol = 0;
         do_start("R1");
         do_cmd(C_WRITE, {addr, rw}, 1'b0);
         chk(ack_ok == match, "R3 address ack matches slave", ack_ok, match);
         if (match && !rw) begin
            for (int k = 0; k < nb; k++) begin
               logic [7:0] d;
               d = 8'($urandom); slv_ack_en = ($urandom % 4) != 0;
               do_cmd(C_WRITE, d, 1'b0);
               chk(wr_last == d, "R3 written byte", wr_last, d);
               chk(ack_ok == slv_ack_en, "R3 data ack", ack_ok, slv_ack_en);
            end
            slv_ack_en = 1;
            if (rs) begin
               do_start("R5");
               do_cmd(C_WRITE, {SLV_ADDR, 1'b1}, 1'b0);
               chk(ack_ok == 1, "R5 re-address ack", ack_ok, 1);
               do_read(1'b1, exp_rd);
            end
         end else if (match) begin
            for (int k = 0; k < nb; k++) do_read(k == nb - 1, exp_rd);
         end
         do_stop();
         chk(viol == 0, "R6 R7 random phase lengths", viol, 0);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #1500000;
      n_chk++; n_err++;
      $display("FAIL R8 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule